// File: doc/BRIEF.md
# Four-Phase Bridge Dead-Time Interlock

This block is the digital core of a gate-drive controller for four half-bridge phases. The phases can be used as a four-phase bridge or as two H-bridges. Each phase takes an upper-switch command and a lower-switch command. It produces one registered gate enable for the upper switch and one for the lower switch. All inputs are synchronous to `clk`.

Every command passes through a minimum-pulse filter. The filtered commands are then arbitrated per phase, with the lower command winning. Each of the eight resulting requests feeds its own turn-on counter. A gate switches off one cycle after its request drops. It switches on only after the programmed dead time has elapsed with the request held.

A global enable forces all eight gates off and clears the counters. A bypass input removes both the arbitration and the delay, so that each gate follows its own command and both switches of a phase may conduct together. The dead time is an unsigned cycle count, written through a one-cycle write strobe.

Top module: `bridge_deadtime_core`

## Requirements
- R1: After reset all gate outputs are 0 and the dead-time register holds DT_RESET (default 25 cycles).
- R2: While `en` is 0 at a clock edge, every gate is 0 after that edge and all turn-on counters restart. Once `en` returns to 1 with a request already filtered and stable, the gate rises on the (dt+1)-th edge that samples `en` high.
- R3: In interlock mode (`dt_bypass`=0), a lower command of 1 turns the lower gate on and holds the upper gate of that phase off, whatever the upper command is.
- R4: In interlock mode, an upper command of 1 with the lower command at 0 turns the upper gate on. With both commands at 0, both gates are 0.
- R5: A gate falls on edge FILT_CYC+1 after its command drops. No dead time is added to turn-off.
- R6: A gate rises on edge FILT_CYC+dt+1 after its command rises in interlock mode. A dead time of 0 gives the shortest delay, FILT_CYC+1 edges, and does not select bypass.
- R7: If a request drops and rises again before its counter expires, the count starts over from the new rising edge.
- R8: With `dt_bypass`=1, each gate follows its own command with a latency of FILT_CYC+1 edges on both edges. Both gates of a phase may be 1 at once.
- R9: A command level held for fewer than FILT_CYC consecutive cycles is ignored and does not change any gate. A level held for FILT_CYC cycles is accepted.
- R10: When `cfg_we` is 1 at an edge, `cfg_dt` is loaded into the dead-time register. The new value applies to every count compared after that edge.
- R11: In interlock mode the two gates of a phase are never 1 together. After one gate of a phase falls, its twin stays 0 for at least dt full cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable. When 0, all gates are off |
| dt_bypass | input | 1 | 1 removes the interlock and the turn-on delay |
| cfg_we | input | 1 | Write strobe for the dead-time register |
| cfg_dt | input | DTW (10) | Dead time in clock cycles |
| hi_cmd | input | NPH (4) | Upper-switch commands, bit n = phase n |
| lo_cmd | input | NPH (4) | Lower-switch commands, bit n = phase n |
| hi_gate | output | NPH (4) | Upper gate enables |
| lo_gate | output | NPH (4) | Lower gate enables |

## Verification
Several properties are checked on every cycle:
- In interlock mode, the two gates of a phase are never on together.
- A gate is only on if `en` was high one cycle earlier, and a low `en` clears all gates at the next edge.
- When the dead time is non-zero, a gate never rises directly after its twin was on.

Other behaviours depend on timing and can only be shown by the bench scenarios. These are the exact turn-on and turn-off latencies, the counter restart on a re-raised request, the rejection of short pulses, the bypass behaviour, and the measured gap compared against the programmed dead time. The bench covers them with directed cases and with a cycle-level reference model. That model runs under random command traffic that includes enable drops.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } bdt_pair_t;

  // Lower command wins in interlock mode; bypass passes both through.
  function automatic bdt_pair_t bdt_arbitrate(input logic hi_c, input logic lo_c,
                                              input logic en_c, input logic byp_c);
    bdt_pair_t r;
    r.lo = en_c & lo_c;
    r.hi = en_c & hi_c & (byp_c | ~lo_c);
    return r;
  endfunction

endpackage

// File: rtl/bdt_pulse_filter.sv
module bdt_pulse_filter #(
  parameter int WIDTH    = 8,
  parameter int FILT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] clean
);

  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic q;
      if (FILT_CYC <= 1) begin : g_pass
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= raw[i];
        end
      end else begin : g_filt
        logic [CW-1:0] run_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            q     <= 1'b0;
            run_q <= '0;
          end else if (raw[i] != q) begin
            if (run_q == CW'(FILT_CYC - 1)) begin
              q     <= raw[i];
              run_q <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end else begin
            run_q <= '0;
          end
        end
      end
      assign clean[i] = q;
    end
  endgenerate

endmodule

// File: rtl/bdt_phase_arbiter.sv
module bdt_phase_arbiter
  import bdt_pkg::*;
(
  input  logic hi_f,
  input  logic lo_f,
  input  logic en,
  input  logic byp,
  output logic req_hi,
  output logic req_lo
);

  bdt_pair_t res;

  always_comb begin
    res    = bdt_arbitrate(hi_f, lo_f, en, byp);
    req_hi = res.hi;
    req_lo = res.lo;
  end

endmodule

// File: rtl/bdt_turnon_delay.sv
module bdt_turnon_delay #(
  parameter int DTW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           byp,
  input  logic           req,
  input  logic [DTW-1:0] dt,
  output logic           gate
);

  logic [DTW-1:0] cnt_q;
  logic           gate_q;

  always_ff @(posedge clk) begin
    if (rst || !en || !req) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (byp) begin
      cnt_q  <= '0;
      gate_q <= 1'b1;
    end else if (!gate_q) begin
      if (cnt_q == dt) begin
        cnt_q  <= '0;
        gate_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + DTW'(1);
      end
    end
  end

  assign gate = gate_q;

endmodule

// File: rtl/bridge_deadtime_core.sv
module bridge_deadtime_core #(
  parameter int NPH      = 4,
  parameter int DTW      = 10,
  parameter int FILT_CYC = 4,
  parameter int DT_RESET = 25
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           dt_bypass,
  input  logic           cfg_we,
  input  logic [DTW-1:0] cfg_dt,
  input  logic [NPH-1:0] hi_cmd,
  input  logic [NPH-1:0] lo_cmd,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate
);

  localparam int NCMD = 2 * NPH;

  logic [DTW-1:0]  dt_q;
  logic [NCMD-1:0] cmd_clean;
  logic [NPH-1:0]  hi_f, lo_f, req_hi, req_lo;

  // dead-time register
  always_ff @(posedge clk) begin
    if (rst)         dt_q <= DTW'(DT_RESET);
    else if (cfg_we) dt_q <= cfg_dt;
  end

  bdt_pulse_filter #(.WIDTH(NCMD), .FILT_CYC(FILT_CYC)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw   ({lo_cmd, hi_cmd}),
    .clean (cmd_clean)
  );

  assign hi_f = cmd_clean[NPH-1:0];
  assign lo_f = cmd_clean[NCMD-1:NPH];

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      bdt_phase_arbiter u_arb (
        .hi_f   (hi_f[p]),
        .lo_f   (lo_f[p]),
        .en     (en),
        .byp    (dt_bypass),
        .req_hi (req_hi[p]),
        .req_lo (req_lo[p])
      );

      bdt_turnon_delay #(.DTW(DTW)) u_dly_hi (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .byp  (dt_bypass),
        .req  (req_hi[p]),
        .dt   (dt_q),
        .gate (hi_gate[p])
      );

      bdt_turnon_delay #(.DTW(DTW)) u_dly_lo (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .byp  (dt_bypass),
        .req  (req_lo[p]),
        .dt   (dt_q),
        .gate (lo_gate[p])
      );
    end
  endgenerate

endmodule

// File: rtl/bdt_checker.sv
module bdt_checker #(
  parameter int NPH = 4,
  parameter int DTW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           dt_bypass,
  input logic [NPH-1:0] hi_gate,
  input logic [NPH-1:0] lo_gate,
  input logic [DTW-1:0] dt_val
);

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hi_gate == '0 && lo_gate == '0));

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_chk
      // R11
      interlock_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dt_bypass) |-> !(hi_gate[p] && lo_gate[p]));

      // R2
      gate_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_gate[p] || lo_gate[p]) |-> $past(en));

      // R11
      hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_gate[p]) && !$past(dt_bypass) && !$past(dt_bypass, 2) &&
         $past(dt_val) != '0) |-> !$past(lo_gate[p]));

      // R11
      lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lo_gate[p]) && !$past(dt_bypass) && !$past(dt_bypass, 2) &&
         $past(dt_val) != '0) |-> !$past(hi_gate[p]));
    end
  endgenerate

endmodule

bind bridge_deadtime_core bdt_checker #(.NPH(NPH), .DTW(DTW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .dt_bypass (dt_bypass),
  .hi_gate   (hi_gate),
  .lo_gate   (lo_gate),
  .dt_val    (dt_q)
);

// File: tb/sim_bridge_deadtime_core.sv
module sim_bridge_deadtime_core;

  localparam int NPH  = 4;
  localparam int DTW  = 10;
  localparam int F    = 4;
  localparam int DTR  = 25;
  localparam int NCMD = 2 * NPH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, dt_bypass = 1'b0, cfg_we = 1'b0;
  logic [DTW-1:0] cfg_dt = '0;
  logic [NPH-1:0] hi_cmd = '0, lo_cmd = '0;
  logic [NPH-1:0] hi_gate, lo_gate;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0, gap_on = 1'b0;
  int seg_dt = 0;

  always #5 clk = ~clk;

  bridge_deadtime_core #(.NPH(NPH), .DTW(DTW), .FILT_CYC(F), .DT_RESET(DTR)) u0 (
    .clk(clk), .rst(rst), .en(en), .dt_bypass(dt_bypass), .cfg_we(cfg_we),
    .cfg_dt(cfg_dt), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  // ---------------- reference model (from the requirements) ----------------
  logic [NCMD-1:0] m_fq, m_g, m_rq;
  int m_fc[NCMD];
  int m_cnt[NCMD];
  int mdt;

  function automatic logic exp_req(input logic is_hi, input logic own_c,
                                   input logic lo_c, input logic e, input logic b);
    if (!e) return 1'b0;
    if (!is_hi) return own_c;
    return own_c & (b | ~lo_c);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fq = '0; m_g = '0; m_rq = '0; mdt = DTR;
      for (int k = 0; k < NCMD; k++) begin m_fc[k] = 0; m_cnt[k] = 0; end
    end else begin
      logic [NCMD-1:0] raw;
      raw = {lo_cmd, hi_cmd};
      for (int p = 0; p < NPH; p++) begin
        m_rq[p]     = exp_req(1'b1, m_fq[p], m_fq[p+NPH], en, dt_bypass);
        m_rq[p+NPH] = exp_req(1'b0, m_fq[p+NPH], 1'b0, en, dt_bypass);
      end
      for (int k = 0; k < NCMD; k++) begin
        if (!m_rq[k]) begin m_cnt[k] = 0; m_g[k] = 1'b0; end
        else if (dt_bypass) begin m_cnt[k] = 0; m_g[k] = 1'b1; end
        else if (!m_g[k]) begin
          if (m_cnt[k] == mdt) begin m_g[k] = 1'b1; m_cnt[k] = 0; end
          else m_cnt[k] = m_cnt[k] + 1;
        end
      end
      for (int k = 0; k < NCMD; k++) begin
        if (raw[k] != m_fq[k]) begin
          if (m_fc[k] == F - 1) begin m_fq[k] = raw[k]; m_fc[k] = 0; end
          else m_fc[k] = m_fc[k] + 1;
        end else m_fc[k] = 0;
      end
      if (cfg_we) mdt = int'(cfg_dt);
    end
  end

  // ---------------- per-cycle compare and gap tracking ----------------
  int off_run[NPH];
  int last_side[NPH];
  logic [NPH-1:0] prev_h, prev_l;

  always @(negedge clk) begin
    if (!rst && chk_on) begin
      n_chk++;
      if ({lo_gate, hi_gate} !== m_g) begin
        n_fail++;
        $display("FAIL R3 R4 R5 R6 model compare: act=%h exp=%h", {lo_gate, hi_gate}, m_g);
      end
    end
    if (!rst && gap_on) begin
      for (int p = 0; p < NPH; p++) begin
        if (hi_gate[p] && lo_gate[p]) begin
          n_chk++; n_fail++;
          $display("FAIL R11 phase %0d both on: act=11 exp=not 11", p);
        end
        if ((hi_gate[p] && !prev_h[p] && last_side[p] == 1) ||
            (lo_gate[p] && !prev_l[p] && last_side[p] == 0)) begin
          n_chk++;
          if (off_run[p] < seg_dt) begin
            n_fail++;
            $display("FAIL R11 phase %0d gap: act=%0d exp>=%0d", p, off_run[p], seg_dt);
          end
        end
        if (hi_gate[p]) last_side[p] = 0;
        if (lo_gate[p]) last_side[p] = 1;
        off_run[p] = (hi_gate[p] || lo_gate[p]) ? 0 : off_run[p] + 1;
      end
      prev_h = hi_gate;
      prev_l = lo_gate;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_dt(input int v);
    cfg_dt = DTW'(v);
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst = 1'b0;
    chk("R1 reset gates", {lo_gate, hi_gate}, '0);
    chk_on = 1'b1;

    // R1 R6: default dead time on turn-on
    lo_cmd[0] = 1'b1;
    tick(F + DTR);     chk("R6 default dt, before", lo_gate[0], 1'b0);
    tick(1);           chk("R1 default dt, rise", lo_gate[0], 1'b1);

    // R5: immediate turn-off
    lo_cmd[0] = 1'b0;
    tick(F);           chk("R5 off, before", lo_gate[0], 1'b1);
    tick(1);           chk("R5 off", lo_gate[0], 1'b0);

    // R10 R4: new dead time, upper alone
    set_dt(3);
    hi_cmd[1] = 1'b1;
    tick(F + 3);       chk("R10 dt=3 before", hi_gate[1], 1'b0);
    tick(1);           chk("R4 upper on", hi_gate[1], 1'b1);

    // R3: lower wins
    lo_cmd[1] = 1'b1;
    tick(F + 1);       chk("R3 upper forced off", hi_gate[1], 1'b0);
    tick(2);           chk("R3 lower waits", lo_gate[1], 1'b0);
    tick(1);           chk("R3 lower on", lo_gate[1], 1'b1);

    // R11: lower released, upper waits dead time
    lo_cmd[1] = 1'b0;
    tick(F + 1);       chk("R5 lower off", lo_gate[1], 1'b0);
    tick(2);           chk("R11 upper held in gap", hi_gate[1], 1'b0);
    tick(1);           chk("R11 upper after gap", hi_gate[1], 1'b1);

    // R4: both off
    hi_cmd[1] = 1'b0;
    tick(F + 1);       chk("R4 both off", {lo_gate[1], hi_gate[1]}, 2'b00);

    // R6: zero dead time is minimum, not bypass
    set_dt(0);
    lo_cmd[2] = 1'b1;
    tick(F);           chk("R6 dt=0 before", lo_gate[2], 1'b0);
    tick(1);           chk("R6 dt=0 rise", lo_gate[2], 1'b1);
    lo_cmd[2] = 1'b0;
    tick(F + 2);

    // R7: restart on re-raised request
    set_dt(10);
    lo_cmd[3] = 1'b1;
    tick(8);
    lo_cmd[3] = 1'b0;
    tick(F);
    lo_cmd[3] = 1'b1;
    tick(F + 10);      chk("R7 restart, still off", lo_gate[3], 1'b0);
    tick(1);           chk("R7 restart, rise", lo_gate[3], 1'b1);
    lo_cmd[3] = 1'b0;
    tick(F + 2);

    // R9: short pulse ignored, F-cycle pulse accepted
    set_dt(2);
    hi_cmd[0] = 1'b1;
    tick(F - 1);
    hi_cmd[0] = 1'b0;
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 20; i++) begin tick(1); seen |= hi_gate[0]; end
      chk("R9 short pulse ignored", seen, 1'b0);
    end
    hi_cmd[0] = 1'b1;
    tick(F);
    hi_cmd[0] = 1'b0;
    tick(3);           chk("R9 full pulse accepted", hi_gate[0], 1'b1);
    tick(F + 2);       chk("R9 pulse ended", hi_gate[0], 1'b0);

    // R2: enable drop and full dead time after return
    lo_cmd[0] = 1'b1;
    tick(F + 3);       chk("R2 lower on before disable", lo_gate[0], 1'b1);
    en = 1'b0;
    tick(1);           chk("R2 disable forces off", {lo_gate, hi_gate}, '0);
    tick(3);
    en = 1'b1;
    tick(2);           chk("R2 full dt after enable", lo_gate[0], 1'b0);
    tick(1);           chk("R2 rise after enable", lo_gate[0], 1'b1);

    // R8: bypass
    lo_cmd = '0;
    en = 1'b0;
    tick(F + 2);
    dt_bypass = 1'b1;
    en = 1'b1;
    hi_cmd[2] = 1'b1;
    lo_cmd[2] = 1'b1;
    tick(F);           chk("R8 bypass before", {lo_gate[2], hi_gate[2]}, 2'b00);
    tick(1);           chk("R8 bypass both on", {lo_gate[2], hi_gate[2]}, 2'b11);
    hi_cmd[2] = 1'b0;
    tick(F);           chk("R8 bypass upper still on", hi_gate[2], 1'b1);
    tick(1);           chk("R8 bypass upper off", {lo_gate[2], hi_gate[2]}, 2'b10);
    lo_cmd[2] = 1'b0;
    tick(F + 2);
    en = 1'b0;
    tick(2);
    dt_bypass = 1'b0;

    // random segments, model compare every cycle, R11 gap in interlock
    for (int seg = 0; seg < 8; seg++) begin
      en = 1'b0;
      hi_cmd = '0;
      lo_cmd = '0;
      tick(F + 2);
      dt_bypass = (seg % 4 == 3);
      seg_dt = int'($urandom % 40);
      set_dt(seg_dt);
      for (int p = 0; p < NPH; p++) begin off_run[p] = 0; last_side[p] = -1; end
      prev_h = '0;
      prev_l = '0;
      gap_on = !dt_bypass;
      en = 1'b1;
      for (int c = 0; c < 1500; c++) begin
        for (int p = 0; p < NPH; p++) begin
          if ($urandom % 10 == 0) hi_cmd[p] = ~hi_cmd[p];
          if ($urandom % 12 == 0) lo_cmd[p] = ~lo_cmd[p];
        end
        en = ($urandom % 600 != 0);
        tick(1);
      end
      gap_on = 1'b0;
    end
    en = 1'b0;
    tick(2);
    dt_bypass = 1'b0;
    tick(2);

    summary();
    $finish;
  end

endmodule